// File: doc/BRIEF.md
# Condition Code Register and Flag Unit

This block holds the 8-bit condition code register of a small CPU and the logic that feeds it. Arithmetic results from add, add-with-extend, subtract, subtract-with-extend, compare and negate are turned into half-carry, negative, zero, overflow and carry flags. The operation can be byte, word or longword wide. Software can load the whole register, or combine it with an immediate by AND, OR or XOR. A store reads the register from `ccr_q`.

The register's mask bits gate interrupt acceptance. The top mask bit blocks every maskable request, and the non-maskable request always passes. The first user bit can also block a lower-priority class when a configuration input enables that. Exception entry forces the top mask bit on. The block also clears bit 0 of the 24-bit program counter to form the fetch address, because instructions are always whole 16-bit words.

Top module: `ccr_flag_unit`

## Requirements
- R1: In a cycle with `rst` high, the next clock edge loads `ccr_q` with 0x80. The bit layout is: bit 7 = interrupt mask, bit 6 = user/mask bit, bit 5 = half-carry, bit 4 = spare user bit, bit 3 = negative, bit 2 = zero, bit 1 = overflow, bit 0 = carry.
- R2: When `sw_valid` is high, `sw_op` selects how the register is updated from `sw_data` at the next edge: 0 = load, 1 = AND, 2 = OR, 3 = XOR.
- R3: For an ALU update, `alu_size` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. The half-carry flag is the carry or borrow out of bit 3, 11 or 27 respectively.
- R4: The negative flag is the result's top bit at the operation width. Overflow is signed overflow. Carry is the carry out for add operations and the borrow for subtract, compare and negate.
- R5: For non-extended operations, Z is set exactly when the result is zero. The extended operations (`alu_op` 1 and 3) also add in, or subtract, the current C. They keep Z when the result is zero and clear Z otherwise.
- R6: `alu_op` encodings are 0 = add, 1 = add with extend, 2 = subtract, 3 = subtract with extend, 4 = compare, 5 = negate. All compute `opa` op `opb`, except negate, which computes 0 − `opa`. An ALU update rewrites only bits 5 and 3..0.
- R7: With no software write, no ALU update and no exception entry, the register holds its value. When `sw_valid` and `alu_valid` are high together, the software operation is applied and the ALU update is discarded.
- R8: `exc_entry` sets bit 7 at the next edge, even when a software write or ALU update lands in the same cycle. The other bits take the value that write or update gives them.
- R9: `irq_accept` is `irq_req` gated off while bit 7 is 1. `nmi_accept` follows `nmi_req` whatever the register holds.
- R10: `irq_low_accept` is `irq_low_req`, blocked by bit 7. It is also blocked by bit 6 while `ui_mask_en` is 1.
- R11: `fetch_addr` equals `pc` with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Update flags from this cycle's operation |
| alu_op | input | 3 | Arithmetic operation code |
| alu_size | input | 2 | Operand width select |
| opa | input | 32 | First operand (negate operand) |
| opb | input | 32 | Second operand |
| sw_valid | input | 1 | Software register operation |
| sw_op | input | 2 | Load / AND / OR / XOR select |
| sw_data | input | 8 | Immediate for software operation |
| exc_entry | input | 1 | Start of exception handling |
| irq_req | input | 1 | Maskable interrupt request |
| irq_low_req | input | 1 | Lower-priority maskable request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ui_mask_en | input | 1 | Lets bit 6 mask the lower class |
| pc | input | 24 | Program counter |
| ccr_q | output | 8 | Register contents (store path) |
| irq_accept | output | 1 | Maskable request accepted |
| irq_low_accept | output | 1 | Lower-class request accepted |
| nmi_accept | output | 1 | Non-maskable request accepted |
| fetch_addr | output | 24 | Word-aligned fetch address |

## Verification
Exception entry can fall in the same cycle as a software write or a flag update. So can a software write and a flag update. Directed cycles load a cleared mask bit while raising `exc_entry`, and issue an add alongside a load. Random traffic then overlaps all three freely. A behavioural model resolves each collision by R7 and R8, and every bit of `ccr_q`, along with the interrupt gates that depend on it, is compared on the following cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W     = 8;
    localparam int BIT_IMASK = 7;
    localparam int BIT_UI    = 6;
    localparam int BIT_HALF  = 5;
    localparam int BIT_USR   = 4;
    localparam int BIT_NEG   = 3;
    localparam int BIT_ZERO  = 2;
    localparam int BIT_OVF   = 1;
    localparam int BIT_CARRY = 0;

    localparam int NUM_SIZES = 3;
    localparam logic [CCR_W-1:0] CCR_RESET = 8'h80;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDX = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBX = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SW_LOAD = 2'd0,
        SW_AND  = 2'd1,
        SW_OR   = 2'd2,
        SW_XOR  = 2'd3
    } sw_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic int size_bits(input int idx);
        return 8 << idx;
    endfunction

    function automatic logic is_extended(input alu_op_e op);
        return (op == OP_ADDX) || (op == OP_SUBX);
    endfunction

    function automatic logic is_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP) || (op == OP_NEG);
    endfunction

    function automatic int size_index(input size_e sz);
        case (sz)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e             op,
    input  size_e               size,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                c_in,
    input  logic                z_in,
    output flags_t              flags
);

    localparam int TOP_W = size_bits(NUM_SIZES - 1);

    flags_t per_size [NUM_SIZES];

    logic ext_op;
    logic sub_op;
    logic neg_op;

    assign ext_op = is_extended(op);
    assign sub_op = is_subtract(op);
    assign neg_op = (op == OP_NEG);

    initial begin
        assert (DATA_W >= TOP_W)
            else $error("operand width below largest operation size");
    end

    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_size
        localparam int W  = size_bits(i);
        localparam int HB = W - 5;

        logic [W-1:0] a_op;
        logic [W-1:0] b_op;
        logic [W:0]   res;
        logic [W:0]   carries;
        logic         cin;
        logic         res_zero;
        flags_t       f;

        always_comb begin
            cin  = ext_op & c_in;
            a_op = neg_op ? '0 : opa[W-1:0];
            b_op = neg_op ? opa[W-1:0] : opb[W-1:0];
            if (sub_op)
                res = {1'b0, a_op} - {1'b0, b_op} - {{W{1'b0}}, cin};
            else
                res = {1'b0, a_op} + {1'b0, b_op} + {{W{1'b0}}, cin};
            // carry (or borrow) into each bit position
            carries  = {1'b0, a_op} ^ {1'b0, b_op} ^ res;
            res_zero = (res[W-1:0] == '0);
            f.h = carries[HB+1];
            f.n = res[W-1];
            f.c = res[W];
            f.z = ext_op ? (z_in & res_zero) : res_zero;
            if (sub_op)
                f.v = (a_op[W-1] ^ b_op[W-1]) & (res[W-1] ^ a_op[W-1]);
            else
                f.v = ~(a_op[W-1] ^ b_op[W-1]) & (res[W-1] ^ a_op[W-1]);
        end

        assign per_size[i] = f;
    end

    assign flags = per_size[size_index(size)];

endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alu_valid,
    input  flags_t           alu_flags,
    input  logic             sw_valid,
    input  sw_op_e           sw_op,
    input  logic [CCR_W-1:0] sw_data,
    input  logic             exc_entry,
    output logic [CCR_W-1:0] q
);

    logic [CCR_W-1:0] d;

    always_comb begin
        d = q;
        if (sw_valid) begin
            case (sw_op)
                SW_LOAD: d = sw_data;
                SW_AND:  d = q & sw_data;
                SW_OR:   d = q | sw_data;
                SW_XOR:  d = q ^ sw_data;
                default: d = q;
            endcase
        end else if (alu_valid) begin
            d[BIT_HALF]  = alu_flags.h;
            d[BIT_NEG]   = alu_flags.n;
            d[BIT_ZERO]  = alu_flags.z;
            d[BIT_OVF]   = alu_flags.v;
            d[BIT_CARRY] = alu_flags.c;
        end
        if (exc_entry)
            d[BIT_IMASK] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= CCR_RESET;
        else     q <= d;
    end

    p_exc_sets_mask_r8: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> q[BIT_IMASK]);

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!sw_valid && !alu_valid && !exc_entry) |=> $stable(q));

    p_alu_keeps_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !sw_valid && !exc_entry) |=>
            (q[BIT_IMASK] == $past(q[BIT_IMASK])) && (q[BIT_UI] == $past(q[BIT_UI]))
            && (q[BIT_USR] == $past(q[BIT_USR])));

    p_and_never_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_valid && sw_op == SW_AND && !exc_entry) |=> ((q & ~$past(q)) == '0));

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
    input  logic imask,
    input  logic ui_bit,
    input  logic ui_mask_en,
    input  logic irq_req,
    input  logic irq_low_req,
    input  logic nmi_req,
    output logic irq_accept,
    output logic irq_low_accept,
    output logic nmi_accept
);

    logic low_blocked;

    assign low_blocked    = imask | (ui_mask_en & ui_bit);
    assign irq_accept     = irq_req & ~imask;
    assign irq_low_accept = irq_low_req & ~low_blocked;
    assign nmi_accept     = nmi_req;

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [2:0]        alu_op,
    input  logic [1:0]        alu_size,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sw_valid,
    input  logic [1:0]        sw_op,
    input  logic [7:0]        sw_data,
    input  logic              exc_entry,
    input  logic              irq_req,
    input  logic              irq_low_req,
    input  logic              nmi_req,
    input  logic              ui_mask_en,
    input  logic [PC_W-1:0]   pc,
    output logic [7:0]        ccr_q,
    output logic              irq_accept,
    output logic              irq_low_accept,
    output logic              nmi_accept,
    output logic [PC_W-1:0]   fetch_addr
);

    flags_t alu_flags;

    ccr_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .op    (alu_op_e'(alu_op)),
        .size  (size_e'(alu_size)),
        .opa   (opa),
        .opb   (opb),
        .c_in  (ccr_q[BIT_CARRY]),
        .z_in  (ccr_q[BIT_ZERO]),
        .flags (alu_flags)
    );

    ccr_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .alu_valid (alu_valid),
        .alu_flags (alu_flags),
        .sw_valid  (sw_valid),
        .sw_op     (sw_op_e'(sw_op)),
        .sw_data   (sw_data),
        .exc_entry (exc_entry),
        .q         (ccr_q)
    );

    ccr_irq_gate u_gate (
        .imask          (ccr_q[BIT_IMASK]),
        .ui_bit         (ccr_q[BIT_UI]),
        .ui_mask_en     (ui_mask_en),
        .irq_req        (irq_req),
        .irq_low_req    (irq_low_req),
        .nmi_req        (nmi_req),
        .irq_accept     (irq_accept),
        .irq_low_accept (irq_low_accept),
        .nmi_accept     (nmi_accept)
    );

    // instructions are whole 16-bit words: bit 0 never reaches the fetch bus
    assign fetch_addr = {pc[PC_W-1:1], 1'b0};

    p_nmi_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> nmi_accept);

    p_mask_blocks_irq_r9: assert property (@(posedge clk) disable iff (rst)
        ccr_q[BIT_IMASK] |-> !irq_accept);

    p_ui_blocks_low_r10: assert property (@(posedge clk) disable iff (rst)
        (ui_mask_en && ccr_q[BIT_UI]) |-> !irq_low_accept);

    p_low_needs_unmasked_r10: assert property (@(posedge clk) disable iff (rst)
        irq_low_accept |-> !ccr_q[BIT_IMASK]);

endmodule

// File: tb/ccr_flag_unit_tb.sv
`timescale 1ns/1ps
module ccr_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        alu_valid;
    logic [2:0]  alu_op;
    logic [1:0]  alu_size;
    logic [31:0] opa, opb;
    logic        sw_valid;
    logic [1:0]  sw_op;
    logic [7:0]  sw_data;
    logic        exc_entry;
    logic        irq_req, irq_low_req, nmi_req, ui_mask_en;
    logic [23:0] pc;
    logic [7:0]  ccr_q;
    logic        irq_accept, irq_low_accept, nmi_accept;
    logic [23:0] fetch_addr;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;
    logic [7:0] model;

    always #10 clk = ~clk;

    ccr_flag_unit u_dut (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op), .alu_size(alu_size),
        .opa(opa), .opb(opb), .sw_valid(sw_valid), .sw_op(sw_op), .sw_data(sw_data),
        .exc_entry(exc_entry), .irq_req(irq_req), .irq_low_req(irq_low_req),
        .nmi_req(nmi_req), .ui_mask_en(ui_mask_en), .pc(pc), .ccr_q(ccr_q),
        .irq_accept(irq_accept), .irq_low_accept(irq_low_accept),
        .nmi_accept(nmi_accept), .fetch_addr(fetch_addr)
    );

    // behavioural flag model: returns {h,n,z,v,c}
    function automatic logic [4:0] ref_flags(int op, int sz, logic [31:0] ain, logic [31:0] bin,
                                             logic c_old, logic z_old);
        int w, hb;
        longint msk, hm, a, b, r, cin;
        bit ext, sub, h, c, n, v, z, sa, sb, sr;
        w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        msk = (64'sd1 <<< w) - 1;
        hb  = (sz == 0) ? 3 : (sz == 1) ? 11 : 27;
        hm  = (64'sd1 <<< (hb + 1)) - 1;
        ext = (op == 1) || (op == 3);
        sub = (op >= 2);
        cin = (ext && c_old) ? 1 : 0;
        if (op == 5) begin a = 0; b = longint'(ain) & msk; end
        else begin a = longint'(ain) & msk; b = longint'(bin) & msk; end
        if (sub) begin
            r = a - b - cin;
            c = (r < 0);
            h = ((a & hm) < ((b & hm) + cin));
        end else begin
            r = a + b + cin;
            c = (r > msk);
            h = (((a & hm) + (b & hm) + cin) > hm);
        end
        r  = r & msk;
        sa = ((a >> (w - 1)) & 1) != 0;
        sb = ((b >> (w - 1)) & 1) != 0;
        sr = ((r >> (w - 1)) & 1) != 0;
        n  = sr;
        v  = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
        z  = ext ? (z_old && r == 0) : (r == 0);
        return {h, n, z, v, c};
    endfunction

    function automatic logic [7:0] model_next();
        logic [7:0] nx;
        logic [4:0] f;
        nx = model;
        if (sw_valid) begin
            case (sw_op)
                2'd0: nx = sw_data;
                2'd1: nx = model & sw_data;
                2'd2: nx = model | sw_data;
                default: nx = model ^ sw_data;
            endcase
        end else if (alu_valid) begin
            f = ref_flags(int'(alu_op), int'(alu_size), opa, opb, model[0], model[2]);
            nx[5]   = f[4];
            nx[3:0] = f[3:0];
        end
        if (exc_entry) nx[7] = 1'b1;
        if (rst) nx = 8'h80;
        return nx;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string auto_tag();
        if (rst) return "R1";
        if (exc_entry) return "R8";
        if (sw_valid) return (alu_valid ? "R7" : "R2");
        if (alu_valid) return "R4";
        return "R7";
    endfunction

    // one clock: predict, clock, compare away from the edge
    task automatic tick(input string tag);
        logic [7:0] nx;
        nx = model_next();
        @(posedge clk);
        #1;
        model = nx;
        chk(tag, "ccr_q", {24'd0, ccr_q}, {24'd0, model});
        chk("R9", "irq_accept", {31'd0, irq_accept}, {31'd0, irq_req & ~model[7]});
        chk("R9", "nmi_accept", {31'd0, nmi_accept}, {31'd0, nmi_req});
        chk("R10", "irq_low_accept", {31'd0, irq_low_accept},
            {31'd0, irq_low_req & ~model[7] & ~(ui_mask_en & model[6])});
        chk("R11", "fetch_addr", {8'd0, fetch_addr}, {8'd0, pc[23:1], 1'b0});
    endtask

    task automatic idle();
        alu_valid = 0; sw_valid = 0; exc_entry = 0;
    endtask

    task automatic do_sw(input logic [1:0] op, input logic [7:0] d, input string tag);
        idle(); sw_valid = 1; sw_op = op; sw_data = d; tick(tag);
    endtask

    task automatic do_alu(input int op, input int sz, input logic [31:0] a,
                          input logic [31:0] b, input string tag);
        idle(); alu_valid = 1; alu_op = op[2:0]; alu_size = sz[1:0]; opa = a; opb = b;
        tick(tag);
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 5))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF >> ($urandom_range(0, 2) * 8);
            3: return 32'h0000_0FFF << ($urandom_range(0, 4) * 4);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        model = 8'h00;
        rst = 1; idle(); alu_op = 0; alu_size = 0; opa = 0; opb = 0; sw_op = 0; sw_data = 0;
        irq_req = 1; irq_low_req = 1; nmi_req = 0; ui_mask_en = 0; pc = 24'h123457;
        tick("R1");                      // R1: reset loads 0x80
        tick("R1");
        rst = 0;
        idle(); tick("R7");              // R7: holds after reset
        do_sw(2'd0, 8'h00, "R2");        // R2: load clears I -> irq_accept opens (R9)
        do_sw(2'd2, 8'h41, "R2");        // R2: OR sets UI and C
        ui_mask_en = 1; idle(); tick("R10");  // R10: UI blocks the low class
        ui_mask_en = 0; idle(); tick("R10");
        do_sw(2'd3, 8'hFF, "R2");        // R2: XOR
        do_sw(2'd1, 8'h5A, "R2");        // R2: AND
        do_sw(2'd0, 8'h50, "R2");
        do_alu(0, 0, 32'h0F, 32'h01, "R3");                 // R3: byte half-carry
        do_alu(0, 1, 32'h0FFF, 32'h0001, "R3");             // R3: word, bit 11
        do_alu(0, 2, 32'h0FFF_FFFF, 32'h1, "R3");           // R3: long, bit 27
        do_alu(0, 1, 32'h000F, 32'h0001, "R3");             // R3: word, no carry at bit 11
        do_alu(2, 0, 32'h10, 32'h01, "R3");                 // R3: byte borrow at bit 3
        do_alu(2, 3, 32'h1000_0000, 32'h1, "R3");           // R3: size 3 is long
        do_alu(0, 0, 32'h7F, 32'h01, "R4");                 // R4: signed overflow
        do_alu(2, 0, 32'h80, 32'h01, "R4");                 // R4: subtract overflow
        do_alu(0, 0, 32'hFF, 32'h01, "R4");                 // R4: carry, zero
        do_alu(4, 1, 32'h0001, 32'h0002, "R4");             // R4: compare borrow
        do_alu(5, 0, 32'h00, 32'h00, "R6");                 // R6: negate zero
        do_alu(5, 0, 32'h80, 32'h00, "R6");                 // R6: negate most-negative
        do_alu(5, 2, 32'h1, 32'hDEAD, "R6");                // R6: opb ignored by negate
        do_alu(0, 0, 32'h00, 32'h00, "R5");                 // R5: Z set
        do_alu(1, 0, 32'h00, 32'h00, "R5");                 // R5: extended zero keeps Z
        do_alu(0, 0, 32'hFF, 32'h01, "R5");                 // sets C and Z
        do_alu(1, 0, 32'h00, 32'h00, "R5");                 // R5: ADDX adds C
        do_alu(3, 1, 32'h0000, 32'h0000, "R5");             // R5: SUBX, zero-result path
        do_alu(3, 0, 32'h00, 32'h00, "R5");
        idle(); sw_valid = 1; sw_op = 0; sw_data = 8'h00; exc_entry = 1; tick("R8");  // R8
        idle(); sw_valid = 1; sw_op = 0; sw_data = 8'h12;
        alu_valid = 1; alu_op = 0; alu_size = 0; opa = 32'hFF; opb = 32'h1; tick("R7"); // R7
        idle(); alu_valid = 1; alu_op = 0; alu_size = 0; opa = 32'h0F; opb = 32'h1;
        exc_entry = 1; tick("R8");       // R8 with ALU update
        nmi_req = 1; idle(); tick("R9"); // R9: NMI passes with I set
        for (int i = 0; i < 3000; i++) begin
            alu_valid   = ($urandom_range(0, 1) == 1);
            sw_valid    = ($urandom_range(0, 3) == 0);
            exc_entry   = ($urandom_range(0, 7) == 0);
            alu_op      = 3'($urandom_range(0, 5));
            alu_size    = 2'($urandom_range(0, 3));
            opa         = pick_operand();
            opb         = pick_operand();
            sw_op       = 2'($urandom_range(0, 3));
            sw_data     = 8'($urandom);
            irq_req     = 1'($urandom);
            irq_low_req = 1'($urandom);
            nmi_req     = 1'($urandom);
            ui_mask_en  = 1'($urandom);
            pc          = 24'($urandom);
            rst         = ($urandom_range(0, 499) == 0);
            tick(auto_tag());
        end
        rst = 0; idle(); tick("R7");
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule